// File: doc/BRIEF.md
# World-Tagged Translation Lookaside Buffer

A small, fully associative translation cache that two security worlds share. Every entry records the virtual page number, the physical page number, a stored non-secure attribute and the world that installed it. Because the world tag is part of the match, translations from the secure world and the normal world sit side by side without evicting or aliasing each other.

A lookup presents a virtual page number and the requesting world; one cycle later the block answers with hit/miss, the physical page number and the non-secure attribute to put on the bus. A normal-world lookup always comes out non-secure, whatever the entry holds; a secure-world lookup uses the stored attribute, so the secure world can reach both physical spaces. Entries are installed through a refill port fed by an external walker, and a maintenance port clears everything, one world, or one page of one world. Changing the attribute of a mapping means invalidating or refilling it; until then the old attribute keeps being returned.

Top module: `wtlb_top`

## Requirements
- R1: After synchronous active-low reset every entry is invalid and rsp_valid, rsp_hit, rsp_ppn and rsp_ns are all 0.
- R2: A lookup hits only when a valid entry has the same virtual page number and the same world tag as the request; world encoding is 0 = secure, 1 = normal.
- R3: The response is registered: rsp_valid, rsp_hit, rsp_ppn and rsp_ns reflect the lookup presented in the previous cycle; with no lookup, or on a miss, rsp_hit and rsp_ppn are 0.
- R4: A normal-world lookup (lk_world = 1) always returns rsp_ns = 1, on hit and on miss.
- R5: A secure-world lookup returns the stored attribute on a hit and rsp_ns = 0 on a miss.
- R6: Entries of both worlds for the same virtual page coexist, and two secure virtual pages that map to one physical page with different attributes can both hit.
- R7: A refill whose page and world match a valid entry overwrites that entry; otherwise it goes to the lowest-numbered invalid entry; if all are valid it goes to the entry named by a round-robin pointer that starts at 0 and then advances by one modulo the entry count.
- R8: Invalidate code 0 clears every entry.
- R9: Invalidate code 1 clears only the entries whose world tag equals inv_world.
- R10: Invalidate code 2 clears only the entry matching inv_vpn and inv_world; code 3 changes nothing.
- R11: A lookup sees the contents before the clock edge, so a refill in the same cycle is not visible to it; when an invalidate and a refill share a cycle the victim is chosen on the old contents, the invalidate is applied first and the refilled entry survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_world | input | 1 | Requesting world (0 secure, 1 normal) |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page number (0 on miss) |
| rsp_ns | output | 1 | Non-secure attribute for the access |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Virtual page of the new entry |
| fill_world | input | 1 | World tag of the new entry |
| fill_ppn | input | PPN_W | Physical page of the new entry |
| fill_ns | input | 1 | Stored non-secure attribute |
| inv_valid | input | 1 | Invalidate request |
| inv_op | input | 2 | 0 all, 1 by world, 2 by page, 3 none |
| inv_world | input | 1 | World for codes 1 and 2 |
| inv_vpn | input | VPN_W | Page for code 2 |

## Verification
The bench targets the world tag first: the same page installed by both worlds, a secure lookup of a normal-only page, and normal-world lookups of entries stored as secure; a design that dropped the tag from the compare would return the other world's frame, and one that passed the stored attribute through would let the normal world emit secure accesses. It fills the array past capacity to pin down invalid-first then round-robin placement and refills an existing page, where a wrong victim choice loses the wrong translation or leaves two entries hitting. Each invalidate scope is checked against survivors from the other world or page, and same-cycle refill/lookup and refill/invalidate collisions expose a design that forwards fill data or lets the flush kill the new entry; random mixed traffic then runs against a reference model.

// File: rtl/wtlb_pkg.sv
// Shared encodings for the world-tagged TLB.
package wtlb_pkg;
    typedef enum logic [1:0] {
        INV_ALL   = 2'd0,
        INV_WORLD = 2'd1,
        INV_PAGE  = 2'd2,
        INV_NOP   = 2'd3
    } inv_op_e;

    localparam logic WORLD_SECURE = 1'b0;
    localparam logic WORLD_NORMAL = 1'b1;
endpackage

// File: rtl/wtlb_match.sv
// Parallel tag comparator: flags every valid entry whose page and world equal
// the request. Assumes the store never holds two entries with the same tag.
module wtlb_match #(
    parameter int N  = 8,
    parameter int VW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][VW-1:0] vpn,
    input  logic [N-1:0]         world,
    input  logic [VW-1:0]        req_vpn,
    input  logic                 req_world,
    output logic [N-1:0]         hit
);
    // one comparator per entry, world tag included in the match
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid[g] && (vpn[g] == req_vpn) && (world[g] == req_world);
    end

    // R6
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/wtlb_victim.sv
// Refill slot selection: matching entry, else lowest invalid, else the
// round-robin pointer, which advances only when it is used.
module wtlb_victim #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     match,
    input  logic             fill_en,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] rr_q;
    logic             use_rr;

    // pick the slot by priority: match, lowest invalid, pointer
    always_comb begin
        idx = rr_q;
        if (|match) begin
            for (int i = 0; i < N; i++)
                if (match[i]) idx = IDX_W'(i);
        end else begin
            for (int i = N - 1; i >= 0; i--)
                if (!valid[i]) idx = IDX_W'(i);
        end
    end

    assign use_rr = fill_en && !(|match) && (&valid);

    // round-robin pointer, wraps at N
    always_ff @(posedge clk) begin
        if (!rst_n)      rr_q <= '0;
        else if (use_rr) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    // R7
    free_slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(|match) && !(&valid)) |-> !valid[idx]);
endmodule

// File: rtl/wtlb_store.sv
// Entry array with valid bits. Invalidate is applied before the refill write
// in the same cycle, so a refilled slot always ends valid.
module wtlb_store
    import wtlb_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = 20,
    parameter int PW = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [VW-1:0]        fill_vpn,
    input  logic                 fill_world,
    input  logic [PW-1:0]        fill_ppn,
    input  logic                 fill_ns,
    input  logic                 inv_en,
    input  inv_op_e              inv_op,
    input  logic                 inv_world,
    input  logic [VW-1:0]        inv_vpn,
    output logic [N-1:0]         valid_q,
    output logic [N-1:0][VW-1:0] vpn_q,
    output logic [N-1:0]         world_q,
    output logic [N-1:0][PW-1:0] ppn_q,
    output logic [N-1:0]         ns_q
);
    logic [N-1:0] kill;

    for (genvar g = 0; g < N; g++) begin : g_ent
        // decide whether this entry falls inside the invalidate scope
        always_comb begin
            kill[g] = 1'b0;
            if (inv_en) begin
                case (inv_op)
                    INV_ALL:   kill[g] = 1'b1;
                    INV_WORLD: kill[g] = (world_q[g] == inv_world);
                    INV_PAGE:  kill[g] = (world_q[g] == inv_world) && (vpn_q[g] == inv_vpn);
                    default:   kill[g] = 1'b0;
                endcase
            end
        end

        // entry state: clear on reset or invalidate, then write on refill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
                world_q[g] <= 1'b0;
                ppn_q[g]   <= '0;
                ns_q[g]    <= 1'b0;
            end else begin
                if (kill[g]) valid_q[g] <= 1'b0;
                if (fill_en && (fill_idx == IDX_W'(g))) begin
                    valid_q[g] <= 1'b1;
                    vpn_q[g]   <= fill_vpn;
                    world_q[g] <= fill_world;
                    ppn_q[g]   <= fill_ppn;
                    ns_q[g]    <= fill_ns;
                end
            end
        end
    end

    // R8
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_op == INV_ALL && !fill_en) |=> (valid_q == '0));
    // R9
    flush_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_op == INV_WORLD && !inv_world && !fill_en) |=> ((valid_q & ~world_q) == '0));
    // R9
    flush_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_op == INV_WORLD && inv_world && !fill_en) |=> ((valid_q & world_q) == '0));
endmodule

// File: rtl/wtlb_top.sv
// World-tagged fully associative TLB. Lookup answers one cycle later; the
// normal world is always forced to non-secure output. Assumes N >= 2.
module wtlb_top
    import wtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_world,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_ns,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_world,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_ns,
    input  logic             inv_valid,
    input  logic [1:0]       inv_op,
    input  logic             inv_world,
    input  logic [VPN_W-1:0] inv_vpn
);
    logic [ENTRIES-1:0]            valid_q, world_q, ns_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic [ENTRIES-1:0]            lk_hit_vec, fill_hit_vec;
    logic [IDX_W-1:0]              fill_idx;
    logic [PPN_W-1:0]              sel_ppn;
    logic                          sel_ns;

    wtlb_match #(.N(ENTRIES), .VW(VPN_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .vpn(vpn_q), .world(world_q),
        .req_vpn(lk_vpn), .req_world(lk_world), .hit(lk_hit_vec));

    wtlb_match #(.N(ENTRIES), .VW(VPN_W)) u_fill_match (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .vpn(vpn_q), .world(world_q),
        .req_vpn(fill_vpn), .req_world(fill_world), .hit(fill_hit_vec));

    wtlb_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .match(fill_hit_vec),
        .fill_en(fill_valid), .idx(fill_idx));

    wtlb_store #(.N(ENTRIES), .VW(VPN_W), .PW(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_valid), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_world(fill_world), .fill_ppn(fill_ppn), .fill_ns(fill_ns),
        .inv_en(inv_valid), .inv_op(inv_op_e'(inv_op)), .inv_world(inv_world),
        .inv_vpn(inv_vpn),
        .valid_q(valid_q), .vpn_q(vpn_q), .world_q(world_q), .ppn_q(ppn_q), .ns_q(ns_q));

    // gather the data of the (at most one) hitting entry
    always_comb begin
        sel_ppn = '0;
        sel_ns  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) begin
                sel_ppn = sel_ppn | ppn_q[i];
                sel_ns  = sel_ns | ns_q[i];
            end
        end
    end

    // register the lookup response, forcing non-secure for the normal world
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_ns    <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (|lk_hit_vec);
            rsp_ppn   <= lk_valid ? sel_ppn : '0;
            rsp_ns    <= lk_valid && ((lk_world == WORLD_NORMAL) || sel_ns);
        end
    end

    // R4
    normal_is_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_world == WORLD_NORMAL) |=> rsp_ns);
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));
    // R3
    miss_zero_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_ppn == '0));
endmodule

// File: tb/wtlb_top_tb_top.sv
module wtlb_top_tb_top;
    localparam int N = 8;
    localparam int VW = 20;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 0, lk_world = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic          rsp_valid, rsp_hit, rsp_ns;
    logic [PW-1:0] rsp_ppn;
    logic          fill_valid = 0, fill_world = 0, fill_ns = 0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic          inv_valid = 0, inv_world = 0;
    logic [1:0]    inv_op = 2'd3;
    logic [VW-1:0] inv_vpn = '0;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    bit            m_v[N];
    bit            m_w[N];
    bit            m_ns[N];
    logic [VW-1:0] m_vpn[N];
    logic [PW-1:0] m_ppn[N];
    int            m_rr = 0;

    always #10 clk = ~clk;  // 50 MHz

    wtlb_top #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_world(lk_world),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_ns(rsp_ns),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_world(fill_world),
        .fill_ppn(fill_ppn), .fill_ns(fill_ns),
        .inv_valid(inv_valid), .inv_op(inv_op), .inv_world(inv_world), .inv_vpn(inv_vpn));

    function automatic int m_find(logic [VW-1:0] vpn, bit w);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_w[i] == w) return i;
        return -1;
    endfunction

    function automatic int m_victim(logic [VW-1:0] vpn, bit w);
        int k = m_find(vpn, w);
        if (k >= 0) return k;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        k = m_rr;
        m_rr = (m_rr + 1) % N;
        return k;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_rr = 0;
    endtask

    task automatic check(string tag, logic [PW+2:0] got, logic [PW+2:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got valid/hit/ns/ppn=%h expected %h", tag, got, exp);
        end
    endtask

    // one cycle of stimulus; response checked mid-cycle after the edge
    task automatic step(bit lv, logic [VW-1:0] lvpn, bit lw,
                        bit fv, logic [VW-1:0] fvpn, bit fw, logic [PW-1:0] fppn, bit fns,
                        bit iv, logic [1:0] iop, bit iw, logic [VW-1:0] ivpn,
                        string tag);
        int h, vic;
        bit e_hit, e_ns;
        logic [PW-1:0] e_ppn;
        lk_valid = lv; lk_vpn = lvpn; lk_world = lw;
        fill_valid = fv; fill_vpn = fvpn; fill_world = fw; fill_ppn = fppn; fill_ns = fns;
        inv_valid = iv; inv_op = iop; inv_world = iw; inv_vpn = ivpn;
        h = m_find(lvpn, lw);
        e_hit = lv && (h >= 0);
        e_ppn = e_hit ? m_ppn[h] : '0;
        e_ns  = lv && (lw || (e_hit && m_ns[h]));
        vic = fv ? m_victim(fvpn, fw) : 0;
        @(posedge clk);
        if (iv) begin
            for (int i = 0; i < N; i++) begin
                if (iop == 2'd0) m_v[i] = 0;
                else if (iop == 2'd1 && m_w[i] == iw) m_v[i] = 0;
                else if (iop == 2'd2 && m_w[i] == iw && m_vpn[i] == ivpn) m_v[i] = 0;
            end
        end
        if (fv) begin
            m_v[vic] = 1; m_vpn[vic] = fvpn; m_w[vic] = fw; m_ppn[vic] = fppn; m_ns[vic] = fns;
        end
        #5;
        check(tag, {rsp_valid, rsp_hit, rsp_ns, rsp_ppn}, {lv, e_hit, e_ns, e_ppn});
        #5;
    endtask

    task automatic fill(logic [VW-1:0] v, bit w, logic [PW-1:0] p, bit ns);
        step(0, '0, 0, 1, v, w, p, ns, 0, 2'd3, 0, '0, "R3 idle during fill");
    endtask

    task automatic look(logic [VW-1:0] v, bit w, string tag);
        step(1, v, w, 0, '0, 0, '0, 0, 0, 2'd3, 0, '0, tag);
    endtask

    task automatic inval(logic [1:0] op, bit w, logic [VW-1:0] v);
        step(0, '0, 0, 0, '0, 0, '0, 0, 1, op, w, v, "R3 idle during invalidate");
    endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #5;
        // R1: reset outputs
        check("R1 reset outputs", {rsp_valid, rsp_hit, rsp_ns, rsp_ppn}, '0);
        rst_n = 1'b1;
        #5;
        look(20'd5, 0, "R1 empty after reset");

        // R6 coexistence of both worlds on one page
        fill(20'd5, 0, 20'h100, 0);
        fill(20'd5, 1, 20'h200, 0);
        look(20'd5, 0, "R5 secure stored ns=0");
        look(20'd5, 1, "R4 normal forced ns");
        fill(20'd6, 0, 20'h100, 1);
        look(20'd6, 0, "R6 alias ns=1");
        look(20'd5, 0, "R6 alias ns=0");
        fill(20'd7, 1, 20'h300, 0);
        look(20'd7, 0, "R2 world tag mismatch");
        look(20'd7, 1, "R4 normal hit");
        look(20'd9, 1, "R4 normal miss");
        look(20'd9, 0, "R5 secure miss");
        // R7 refill overwrites, stale attribute replaced
        fill(20'd5, 0, 20'h111, 1);
        look(20'd5, 0, "R7 overwrite same tag");
        // R10 page invalidate and no-op code
        inval(2'd2, 0, 20'd5);
        look(20'd5, 0, "R10 page gone");
        look(20'd5, 1, "R10 other world kept");
        inval(2'd3, 0, 20'd6);
        look(20'd6, 0, "R10 code 3 no effect");
        // R9 world invalidate
        inval(2'd1, 1, '0);
        look(20'd5, 1, "R9 normal cleared");
        look(20'd6, 0, "R9 secure kept");
        // R8 all
        inval(2'd0, 0, '0);
        look(20'd6, 0, "R8 all cleared");

        // R7 placement: lowest invalid then round robin
        for (int i = 0; i < N; i++) fill(20'(16 + i), 0, 20'(32'h400 + i), 0);
        fill(20'd40, 0, 20'h500, 1);
        look(20'd16, 0, "R7 slot0 replaced");
        look(20'd17, 0, "R7 slot1 kept");
        look(20'd40, 0, "R7 new entry");
        fill(20'd41, 0, 20'h501, 0);
        look(20'd17, 0, "R7 slot1 replaced");
        look(20'd18, 0, "R7 slot2 kept");

        // R11 same-cycle interactions
        step(1, 20'd50, 0, 1, 20'd50, 0, 20'h600, 1, 0, 2'd3, 0, '0, "R11 fill invisible same cycle");
        look(20'd50, 0, "R11 fill visible next");
        step(0, '0, 0, 1, 20'd51, 1, 20'h700, 0, 1, 2'd0, 0, '0, "R11 flush with fill");
        look(20'd51, 1, "R11 fill survives flush");
        look(20'd50, 0, "R11 others flushed");

        // random traffic against the model
        void'($urandom(32'd1234));
        for (int t = 0; t < 3000; t++) begin
            bit lv = ($urandom % 10) < 7;
            bit fv = ($urandom % 10) < 3;
            bit iv = ($urandom % 20) == 0;
            step(lv, 20'($urandom % 12), 1'($urandom), fv, 20'($urandom % 12), 1'($urandom),
                 20'($urandom), 1'($urandom), iv, 2'($urandom), 1'($urandom), 20'($urandom % 12),
                 "R2/R4/R5/R7 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule